// File: doc/BRIEF.md
# Field Output Sequencer with Repeat

This block turns a stream of picture descriptors into the series of fields that a video output stage shows. Each descriptor gives the picture structure (a whole frame, or a single field of a stated parity), a top-first flag, a repeat flag and a picture coding type. A frame yields two fields, or three when the repeat flag is set. The first field's parity comes from the top-first flag, and the repeated field is always the first one. A field picture yields only its own field.

The video timing logic pulses `field_tick` once per field period. On every tick the block emits one field: it drives `fld_bottom` to select the field and strobes `fld_valid`. It pulses `pic_done` with the last field of a picture, and only then does it take the next descriptor. A tick that finds no picture loaded repeats the last emitted field and raises `underflow`. The block also checks each descriptor as it is accepted. It flags flag misuse on field pictures, field pairs of equal parity, illegal type pairings inside a pair, and a frame that arrives while a pair is still half complete. Flagged pictures are still displayed.

Top module: `field_seq`

## Requirements
- R1: While `rst_n` is low (synchronous), `fld_valid`, `pic_done`, `underflow` and `fmt_error` are 0, `fld_bottom` is 0 (top), and `pic_ready` is 1.
- R2: For a frame picture (`pic_is_field`=0), the first emitted field is top (`fld_bottom`=0) when `pic_tff`=1 and bottom (`fld_bottom`=1) when `pic_tff`=0.
- R3: A frame with `pic_rff`=0 emits exactly two fields: the first field, then the opposite parity.
- R4: A frame with `pic_rff`=1 emits exactly three fields: the first, the opposite, then the first parity again.
- R5: A field picture (`pic_is_field`=1) emits exactly one field, whose parity is `pic_bottom` (1 = bottom).
- R6: A field picture accepted with `pic_tff`=1 or `pic_rff`=1 raises `fmt_error` for one cycle, in the cycle after acceptance.
- R7: Field pictures pair up in order of acceptance. If the second field of a pair has the same parity as the first, `fmt_error` pulses in the cycle after its acceptance.
- R8: Types are coded on `pic_type` as 01 = I, 10 = P, 11 = B, with 00 reserved. A pair is legal only as I then I, I then P, P then P, or B then B. Any other pairing pulses `fmt_error` in the cycle after the second field is accepted.
- R9: One field is emitted per `field_tick`, with `fld_valid` high only in the cycle after a tick. `pic_ready` stays low from the cycle after acceptance until the cycle after the tick that emits the picture's last field.
- R10: `pic_done` is high together with `fld_valid` for the last field of each picture and is low for every other field.
- R11: A tick that finds no picture loaded gives `fld_valid`=1 and `underflow`=1 in the next cycle. `fld_bottom` repeats the last emitted field and `pic_done` stays 0.
- R12: A frame picture accepted while a pair still waits for its second field pulses `fmt_error` in the next cycle and abandons the pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pic_valid | input | 1 | Descriptor offered |
| pic_ready | output | 1 | Descriptor can be accepted (no picture loaded) |
| pic_is_field | input | 1 | 1 = field picture, 0 = frame picture |
| pic_bottom | input | 1 | Parity of a field picture (1 = bottom) |
| pic_tff | input | 1 | Top field first flag |
| pic_rff | input | 1 | Repeat first field flag |
| pic_type | input | 2 | Coding type: 01 I, 10 P, 11 B, 00 reserved |
| field_tick | input | 1 | One pulse per field period |
| fld_valid | output | 1 | A field is being emitted this cycle |
| fld_bottom | output | 1 | Field select (1 = bottom, 0 = top) |
| pic_done | output | 1 | Emitted field is the last one of its picture |
| underflow | output | 1 | Emitted field is a repeat because no picture was loaded |
| fmt_error | output | 1 | Descriptor accepted last cycle broke a structure rule |

## Verification
Every field result (`fld_valid`, `fld_bottom`, `pic_done`, `underflow`) is registered and appears in the cycle after the edge that samples `field_tick`. `fmt_error` appears in the cycle after the edge that accepts a descriptor. `pic_ready` rises in the cycle after the tick that emits the last field. The bench drives on falling edges and holds each stimulus for one cycle. It samples on the next falling edge, so each check lands on the single cycle in which its result is due. Idle cycles between ticks are checked to show that no field is emitted and no descriptor is taken early.

// File: rtl/fseq_pkg.sv
// Shared types for the field output sequencer.
// Assumes: a 2-bit coding type, with code 00 reserved.
package fseq_pkg;
    localparam int PTYPE_W  = 2;
    localparam int MAX_FLDS = 3;

    typedef enum logic [PTYPE_W-1:0] {
        PT_RSVD = 2'b00,
        PT_I    = 2'b01,
        PT_P    = 2'b10,
        PT_B    = 2'b11
    } pic_type_e;

    typedef struct packed {
        logic      is_field;
        logic      bottom;
        logic      tff;
        logic      rff;
        pic_type_e ptype;
    } pic_desc_t;
endpackage

// File: rtl/fseq_desc_slot.sv
// Single-entry descriptor holder. It takes a descriptor only while empty
// and empties when the field generator reports the picture's last field.
// Assumes: release_i is only asserted while loaded.
module fseq_desc_slot
    import fseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  pic_desc_t in_desc,
    input  logic      release_i,
    output logic      in_ready,
    output logic      accept_o,
    output logic      loaded,
    output pic_desc_t desc_q
);
    assign in_ready = !loaded;
    assign accept_o = in_valid && in_ready;

    // Purpose: load on acceptance, clear after the last field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded <= 1'b0;
            desc_q <= '0;
        end else if (accept_o) begin
            loaded <= 1'b1;
            desc_q <= in_desc;
        end else if (release_i) begin
            loaded <= 1'b0;
        end
    end

    assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && !release_i) |=> (loaded && $stable(desc_q)));
endmodule

// File: rtl/fseq_pair_check.sv
// Structure checker run on every accepted descriptor. It tracks an open field
// pair and flags flag misuse, equal parity, bad type pairing, or a frame
// that breaks into an open pair.
// Assumes: accept_i is a single-cycle qualifier for desc_i.
module fseq_pair_check
    import fseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept_i,
    input  pic_desc_t desc_i,
    output logic      fmt_error
);
    logic      pend;
    logic      pend_bottom;
    pic_type_e pend_type;
    logic      bad_now;

    function automatic logic type_ok(input pic_type_e first, input pic_type_e second);
        case (first)
            PT_I:    return (second == PT_I) || (second == PT_P);
            PT_P:    return second == PT_P;
            PT_B:    return second == PT_B;
            default: return 1'b0;
        endcase
    endfunction

    // Purpose: combine all structure rules for the descriptor being accepted.
    always_comb begin
        bad_now = 1'b0;
        if (desc_i.is_field) begin
            if (desc_i.tff || desc_i.rff)
                bad_now = 1'b1;
            if (pend && ((desc_i.bottom == pend_bottom) || !type_ok(pend_type, desc_i.ptype)))
                bad_now = 1'b1;
        end else if (pend) begin
            bad_now = 1'b1;
        end
    end

    // Purpose: track the open pair and register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend        <= 1'b0;
            pend_bottom <= 1'b0;
            pend_type   <= PT_RSVD;
            fmt_error   <= 1'b0;
        end else begin
            fmt_error <= accept_i && bad_now;
            if (accept_i) begin
                pend        <= desc_i.is_field && !pend;
                pend_bottom <= desc_i.bottom;
                pend_type   <= desc_i.ptype;
            end
        end
    end

    assert_err_follows_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_error |-> $past(accept_i));
    assert_frame_closes_pair_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !desc_i.is_field) |=> !pend);
endmodule

// File: rtl/fseq_field_gen.sv
// Field emitter. On every tick it emits the next field of the loaded picture,
// or repeats the last field when nothing is loaded.
// Assumes: ticks are at least two cycles apart, so a freed slot can reload.
module fseq_field_gen
    import fseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      loaded,
    input  pic_desc_t desc,
    output logic      release_o,
    output logic      fld_valid,
    output logic      fld_bottom,
    output logic      pic_done,
    output logic      underflow
);
    localparam int CNT_W = $clog2(MAX_FLDS);

    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] n_flds;
    logic             first_bot;
    logic             cur_bot;
    logic             is_last;

    // Purpose: derive field count, first parity and the current field.
    always_comb begin
        first_bot = desc.is_field ? desc.bottom : !desc.tff;
        if (desc.is_field)
            n_flds = CNT_W'(1);
        else if (desc.rff)
            n_flds = CNT_W'(3);
        else
            n_flds = CNT_W'(2);
        is_last = (idx == n_flds - CNT_W'(1));
        cur_bot = (idx == CNT_W'(1)) ? !first_bot : first_bot;
    end

    assign release_o = tick && loaded && is_last;

    // Purpose: advance the field index and register the field outputs per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            fld_valid  <= 1'b0;
            fld_bottom <= 1'b0;
            pic_done   <= 1'b0;
            underflow  <= 1'b0;
        end else begin
            fld_valid <= tick;
            pic_done  <= release_o;
            underflow <= tick && !loaded;
            if (tick && loaded) begin
                fld_bottom <= cur_bot;
                idx        <= is_last ? '0 : idx + CNT_W'(1);
            end
        end
    end

    assert_repeat_on_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !loaded) |=> (underflow && fld_valid && !pic_done && $stable(fld_bottom)));
    assert_done_with_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (pic_done && fld_valid));
    assert_second_opposite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && loaded && idx == CNT_W'(1)) |=> (fld_bottom != $past(fld_bottom)));
    assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(idx));
endmodule

// File: rtl/field_seq.sv
// Field output sequencer top. It wires the descriptor slot, the structure
// checker and the field emitter together.
// Assumes: field_tick is a single-cycle pulse from the video timing logic.
module field_seq
    import fseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pic_valid,
    output logic       pic_ready,
    input  logic       pic_is_field,
    input  logic       pic_bottom,
    input  logic       pic_tff,
    input  logic       pic_rff,
    input  logic [1:0] pic_type,
    input  logic       field_tick,
    output logic       fld_valid,
    output logic       fld_bottom,
    output logic       pic_done,
    output logic       underflow,
    output logic       fmt_error
);
    pic_desc_t in_desc;
    pic_desc_t cur_desc;
    logic      accept;
    logic      loaded;
    logic      release_w;

    // Purpose: pack the descriptor pins into the shared struct.
    always_comb begin
        in_desc.is_field = pic_is_field;
        in_desc.bottom   = pic_bottom;
        in_desc.tff      = pic_tff;
        in_desc.rff      = pic_rff;
        in_desc.ptype    = pic_type_e'(pic_type);
    end

    fseq_desc_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pic_valid),
        .in_desc   (in_desc),
        .release_i (release_w),
        .in_ready  (pic_ready),
        .accept_o  (accept),
        .loaded    (loaded),
        .desc_q    (cur_desc)
    );

    fseq_pair_check u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .desc_i    (in_desc),
        .fmt_error (fmt_error)
    );

    fseq_field_gen u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (field_tick),
        .loaded     (loaded),
        .desc       (cur_desc),
        .release_o  (release_w),
        .fld_valid  (fld_valid),
        .fld_bottom (fld_bottom),
        .pic_done   (pic_done),
        .underflow  (underflow)
    );

    assert_valid_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fld_valid |-> $past(field_tick));
endmodule

// File: tb/field_seq_test.sv
module field_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pic_valid = 1'b0;
    logic       pic_ready;
    logic       pic_is_field = 1'b0;
    logic       pic_bottom = 1'b0;
    logic       pic_tff = 1'b0;
    logic       pic_rff = 1'b0;
    logic [1:0] pic_type = 2'b01;
    logic       field_tick = 1'b0;
    logic       fld_valid, fld_bottom, pic_done, underflow, fmt_error;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    field_seq uut (
        .clk(clk), .rst_n(rst_n), .pic_valid(pic_valid), .pic_ready(pic_ready),
        .pic_is_field(pic_is_field), .pic_bottom(pic_bottom), .pic_tff(pic_tff),
        .pic_rff(pic_rff), .pic_type(pic_type), .field_tick(field_tick),
        .fld_valid(fld_valid), .fld_bottom(fld_bottom), .pic_done(pic_done),
        .underflow(underflow), .fmt_error(fmt_error)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One tick; returns at the falling edge where the field outputs are due.
    task automatic pulse_tick();
        field_tick = 1'b1;
        @(negedge clk);
        field_tick = 1'b0;
    endtask

    // Offer one descriptor, check the structure flag, then play and check every field.
    task automatic run_pic(input string req, input logic is_f, input logic bot,
                           input logic tff, input logic rff, input logic [1:0] ty,
                           input logic exp_err);
        int  n;
        logic first;
        logic exp_bot;
        while (!pic_ready) @(negedge clk);
        pic_is_field = is_f; pic_bottom = bot; pic_tff = tff; pic_rff = rff; pic_type = ty;
        pic_valid = 1'b1;
        @(negedge clk);
        pic_valid = 1'b0;
        chk(req, "fmt_error after accept", fmt_error, exp_err);
        chk("R9", "ready low while loaded", pic_ready, 1'b0);
        chk("R9", "no field without tick", fld_valid, 1'b0);
        n = is_f ? 1 : (rff ? 3 : 2);
        first = is_f ? bot : !tff;
        for (int i = 0; i < n; i++) begin
            exp_bot = (i == 1) ? !first : first;
            pulse_tick();
            chk(req, "fld_valid", fld_valid, 1'b1);
            chk(is_f ? "R5" : (i == 0 ? "R2" : (i == 2 ? "R4" : "R3")), "fld_bottom", fld_bottom, exp_bot);
            chk("R10", "pic_done", pic_done, i == n - 1);
            chk("R11", "no underflow", underflow, 1'b0);
            if (i == n - 1) begin
                chk("R9", "ready after last field", pic_ready, 1'b1);
            end else begin
                chk("R9", "ready low mid picture", pic_ready, 1'b0);
                @(negedge clk);
                chk("R9", "valid one cycle only", fld_valid, 1'b0);
            end
        end
        @(negedge clk);
        chk("R3", "no extra field", fld_valid, 1'b0);
        chk("R6", "error is one pulse", fmt_error, 1'b0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk("R1", "fld_valid", fld_valid, 1'b0);
        chk("R1", "fld_bottom", fld_bottom, 1'b0);
        chk("R1", "pic_done", pic_done, 1'b0);
        chk("R1", "underflow", underflow, 1'b0);
        chk("R1", "fmt_error", fmt_error, 1'b0);
        chk("R1", "pic_ready", pic_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_frames();
        run_pic("R3", 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0);   // T,B
        run_pic("R4", 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0);   // B,T,B
        run_pic("R4", 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);   // T,B,T
        run_pic("R2", 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0);   // B,T
    endtask

    task automatic test_underflow();
        run_pic("R4", 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0);   // ends on bottom
        pulse_tick();
        chk("R11", "fld_valid", fld_valid, 1'b1);
        chk("R11", "underflow", underflow, 1'b1);
        chk("R11", "repeat bottom", fld_bottom, 1'b1);
        chk("R11", "no pic_done", pic_done, 1'b0);
        @(negedge clk);
        chk("R11", "underflow one pulse", underflow, 1'b0);
        run_pic("R3", 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0);   // ends on bottom
        pulse_tick();
        chk("R11", "repeat again", fld_bottom, 1'b1);
        chk("R11", "underflow again", underflow, 1'b1);
        @(negedge clk);
    endtask

    task automatic test_pairs();
        run_pic("R5", 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0);   // I bottom
        run_pic("R8", 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);   // P top: legal
        run_pic("R6", 1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 1'b1);   // tff on field
        run_pic("R8", 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0);   // I then I legal
        run_pic("R6", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1);   // rff on field
        run_pic("R8", 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0);   // B then B legal
        run_pic("R7", 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);   // P top
        run_pic("R7", 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1);   // P top again
        run_pic("R8", 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);   // P top
        run_pic("R8", 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1);   // then I: illegal
        run_pic("R8", 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0);   // B bottom
        run_pic("R8", 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1);   // then P: illegal
        run_pic("R5", 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0);   // I top opens pair
        run_pic("R12", 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1);  // frame breaks pair
        run_pic("R12", 1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0);  // new pair starts clean
        run_pic("R8", 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);
    endtask

    initial begin
        test_reset();
        test_frames();
        test_underflow();
        test_pairs();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule